// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

The arbiter collects a parameterised number of peripheral interrupt sources. Each source has a pending flag, an enable bit and a 3-bit user level. Among the sources that are both flagged and enabled, the arbiter picks one winner. The winner is the source with the highest level; when levels are equal, the lowest index wins. Its index serves as the vector number. The arbiter raises a request toward the core when the winner's level is strictly above the live core priority.

The core priority is 4 bits wide. Its lower three bits form a field that software can write. Its top bit marks that a trap is in progress. When the core acknowledges a request, the arbiter does four things:
- it saves the current 4-bit priority on an 8-entry stack;
- it raises the field to the winner's level, or to 7 when nesting is disabled;
- it captures the vector number and level in status outputs;
- it leaves the source's flag set.

A return strobe pops the saved priority back into place. Peripherals set flags with set pulses. Software clears flags with a write-one-to-clear mask.

Top module: `irqarb_top`

## Requirements
- R1: A source competes only when its flag and its enable are both 1 and its level is not 0. A flagged source that is disabled, or that has level 0, never drives the request.
- R2: `irqReq` is 1 only when the winner's level, with a 0 prepended, is strictly greater than `cpuLevel`. When the field equals 7, every source is masked.
- R3: The winner has the highest level. Among sources of equal level, the lowest index wins. `irqVec` carries that index and `irqLevel` carries `{0, level}`.
- R4: An accepted `ack` (with `irqReq` 1, `ret` 0 and the stack not full) has these effects on the next cycle:
  - the old `cpuLevel` is pushed;
  - the field takes the winner's level;
  - `statVec` and `statLevel` take the winner's vector and level;
  - the flag stays set.
- R5: While a source is in service, a pending source of the same level but with a lower index stays flagged and does not raise `irqReq` until the service returns.
- R6: While `nestDis` is 1, an accepted `ack` sets the field to 7, but `statLevel` still records the winner's own level. Software field writes are ignored.
- R7: `iplWr` loads `iplData` into the field on the next cycle when nesting is enabled. An accepted `ack` in the same cycle overrides it.
- R8: `ret` with a non-empty stack restores all 4 bits of the saved priority. `ret` with an empty stack leaves `cpuLevel` unchanged and pulses `stackErr` high for exactly one cycle.
- R9: Reset clears the following:
  - flags, enables and status to 0;
  - `cpuLevel` to 0;
  - `stackErr` to 0;
  - the stack to empty.

  Reset sets every source's level to 4.
- R10: Bit i of `setPulse` sets flag i and bit i of `clrMask` clears it. A set wins over a clear in the same cycle.
- R11: An `ack` while the stack holds 8 entries is ignored. The priority and the status do not change.
- R12: `trapSet` sets bit 3 of `cpuLevel`, which masks every user source. `trapClr` clears that bit. `trapSet` wins over `trapClr`.
- R13: When `ret` and `ack` arrive in the same cycle, the return is performed and the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setPulse | input | NUM_SRC | Per-source flag set pulses |
| clrMask | input | NUM_SRC | Write-one-to-clear flag mask |
| enWr | input | 1 | Load the enable vector |
| enData | input | NUM_SRC | New enable vector |
| prioWr | input | 1 | Write one source level |
| prioIdx | input | VEC_W | Source written by prioWr |
| prioData | input | 3 | Level written by prioWr |
| iplWr | input | 1 | Software write of the priority field |
| iplData | input | 3 | Value for the priority field |
| trapSet | input | 1 | Set the trap-in-progress bit |
| trapClr | input | 1 | Clear the trap-in-progress bit |
| nestDis | input | 1 | Nesting-disable mode |
| ack | input | 1 | Core accepts the current request |
| ret | input | 1 | Return-from-interrupt strobe |
| irqReq | output | 1 | Request to the core |
| irqVec | output | VEC_W | Winning vector number |
| irqLevel | output | 4 | Winning level |
| cpuLevel | output | 4 | Current core priority {trap, field} |
| statVec | output | VEC_W | Vector captured at acceptance |
| statLevel | output | 4 | Level captured at acceptance |
| stackErr | output | 1 | Return on empty stack, one-cycle pulse |
| flags | output | NUM_SRC | Pending flags |

## Verification
Every input acts on the clock edge on which it is sampled. The request, the vector, the level, the core priority, the status and the flags show the new state one cycle after a stimulus. The `stackErr` pulse appears in that same following cycle and has cleared again one cycle later.

The driver applies each stimulus on a falling edge and queues the expected outputs after the next rising edge. The monitor compares them on the falling edge that follows. All compared outputs are derived from registers, so the inputs changing on that same falling edge cannot disturb them.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int PRIO_W = 3;
  localparam int LVL_W  = PRIO_W + 1;

  typedef struct packed {
    logic              accept;
    logic [PRIO_W-1:0] acceptIpl;
    logic              pop;
    logic              popErr;
    logic              swWrite;
  } ctrl_strobe_t;
endpackage

// File: rtl/irqarb_pick.sv
module irqarb_pick #(
  parameter int NUM_SRC = 16,
  parameter int VEC_W   = 7
) (
  input  logic [NUM_SRC-1:0]                     pend,
  input  logic [NUM_SRC*irqarb_pkg::PRIO_W-1:0]  prioFlat,
  output logic                                   winValid,
  output logic [VEC_W-1:0]                       winIdx,
  output logic [irqarb_pkg::PRIO_W-1:0]          winPrio
);
  import irqarb_pkg::*;

  // Scan from the highest index down; ">=" lets a lower index take a tie.
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winPrio  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i] && (prioFlat[i*PRIO_W +: PRIO_W] != '0) &&
          (prioFlat[i*PRIO_W +: PRIO_W] >= winPrio)) begin
        winValid = 1'b1;
        winPrio  = prioFlat[i*PRIO_W +: PRIO_W];
        winIdx   = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqarb_ctrl.sv
module irqarb_ctrl (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            winValid,
  input  logic [irqarb_pkg::PRIO_W-1:0]   winPrio,
  input  logic [irqarb_pkg::LVL_W-1:0]    cpuLevel,
  input  logic                            ack,
  input  logic                            ret,
  input  logic                            nestDis,
  input  logic                            iplWr,
  input  logic                            stackEmpty,
  input  logic                            stackFull,
  output logic                            irqReq,
  output irqarb_pkg::ctrl_strobe_t        strobe
);
  import irqarb_pkg::*;

  assign irqReq = winValid && ({1'b0, winPrio} > cpuLevel);

  always_comb begin
    strobe           = '0;
    strobe.pop       = ret && !stackEmpty;
    strobe.popErr    = ret && stackEmpty;
    strobe.accept    = ack && irqReq && !ret && !stackFull;
    strobe.acceptIpl = nestDis ? '1 : winPrio;
    strobe.swWrite   = iplWr && !nestDis && !ret && !strobe.accept;
  end

  // R2 / R12: a field of 7 or a set trap bit must mask every request
  assert_mask_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (cpuLevel[LVL_W-1] == 1'b0 && cpuLevel[PRIO_W-1:0] != '1))
    else $error("request raised while masked");

  // R13: return and acknowledge never both take effect
  assert_ret_beats_ack_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.accept && (strobe.pop || strobe.popErr)))
    else $error("accept together with return");
endmodule

// File: rtl/irqarb_data.sv
module irqarb_data #(
  parameter int NUM_SRC = 16,
  parameter int VEC_W   = 7,
  parameter int DEPTH   = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_SRC-1:0]                     setPulse,
  input  logic [NUM_SRC-1:0]                     clrMask,
  input  logic                                   enWr,
  input  logic [NUM_SRC-1:0]                     enData,
  input  logic                                   prioWr,
  input  logic [VEC_W-1:0]                       prioIdx,
  input  logic [irqarb_pkg::PRIO_W-1:0]          prioData,
  input  logic [irqarb_pkg::PRIO_W-1:0]          iplData,
  input  logic                                   trapSet,
  input  logic                                   trapClr,
  input  irqarb_pkg::ctrl_strobe_t               strobe,
  input  logic [VEC_W-1:0]                       winIdx,
  input  logic [irqarb_pkg::PRIO_W-1:0]          winPrio,
  output logic [NUM_SRC-1:0]                     pend,
  output logic [NUM_SRC*irqarb_pkg::PRIO_W-1:0]  prioFlat,
  output logic [NUM_SRC-1:0]                     flags,
  output logic [irqarb_pkg::LVL_W-1:0]           cpuLevel,
  output logic [VEC_W-1:0]                       statVec,
  output logic [irqarb_pkg::LVL_W-1:0]           statLevel,
  output logic                                   stackErr,
  output logic                                   stackEmpty,
  output logic                                   stackFull
);
  import irqarb_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PRIO_W-1:0] RESET_PRIO = PRIO_W'(4);

  logic [NUM_SRC-1:0] flagQ, enQ;
  logic [PRIO_W-1:0]  iplQ;
  logic               trapQ;
  logic [LVL_W-1:0]   stackMem [DEPTH];
  logic [CNT_W-1:0]   cnt;
  logic [PTR_W-1:0]   pushIdx, popIdx;
  logic [LVL_W-1:0]   popVal;

  // Per-source flag, enable and level registers
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[g] <= 1'b0;
        enQ[g]   <= 1'b0;
        prioFlat[g*PRIO_W +: PRIO_W] <= RESET_PRIO;
      end else begin
        if (setPulse[g])     flagQ[g] <= 1'b1;
        else if (clrMask[g]) flagQ[g] <= 1'b0;
        if (enWr) enQ[g] <= enData[g];
        if (prioWr && prioIdx == VEC_W'(g))
          prioFlat[g*PRIO_W +: PRIO_W] <= prioData;
      end
    end

    // R10: a set pulse always leaves the flag set
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rstN)
      setPulse[g] |=> flagQ[g])
      else $error("set pulse lost");
  end

  assign pend     = flagQ & enQ;
  assign flags    = flagQ;
  assign cpuLevel = {trapQ, iplQ};

  // Saved-level stack
  assign stackEmpty = (cnt == '0);
  assign stackFull  = (cnt == CNT_W'(DEPTH));
  assign pushIdx    = PTR_W'(cnt);
  assign popIdx     = PTR_W'(cnt - CNT_W'(1));
  assign popVal     = stackMem[popIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.pop) begin
      cnt <= cnt - CNT_W'(1);
    end else if (strobe.accept) begin
      cnt <= cnt + CNT_W'(1);
      stackMem[pushIdx] <= cpuLevel;
    end
  end

  // Core priority field and trap bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      iplQ  <= '0;
      trapQ <= 1'b0;
    end else begin
      if (strobe.pop)          iplQ <= popVal[PRIO_W-1:0];
      else if (strobe.accept)  iplQ <= strobe.acceptIpl;
      else if (strobe.swWrite) iplQ <= iplData;

      if (trapSet)         trapQ <= 1'b1;
      else if (strobe.pop) trapQ <= popVal[LVL_W-1];
      else if (trapClr)    trapQ <= 1'b0;
    end
  end

  // Status captured at acceptance, error pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statVec   <= '0;
      statLevel <= '0;
      stackErr  <= 1'b0;
    end else begin
      stackErr <= strobe.popErr;
      if (strobe.accept) begin
        statVec   <= winIdx;
        statLevel <= {1'b0, winPrio};
      end
    end
  end

  // R11: the stack never holds more than DEPTH entries
  assert_stack_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH))
    else $error("stack overflow");
endmodule

// File: rtl/irqarb_top.sv
module irqarb_top #(
  parameter int NUM_SRC = 16,
  parameter int VEC_W   = 7,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] setPulse,
  input  logic [NUM_SRC-1:0] clrMask,
  input  logic               enWr,
  input  logic [NUM_SRC-1:0] enData,
  input  logic               prioWr,
  input  logic [VEC_W-1:0]   prioIdx,
  input  logic [2:0]         prioData,
  input  logic               iplWr,
  input  logic [2:0]         iplData,
  input  logic               trapSet,
  input  logic               trapClr,
  input  logic               nestDis,
  input  logic               ack,
  input  logic               ret,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec,
  output logic [3:0]         irqLevel,
  output logic [3:0]         cpuLevel,
  output logic [VEC_W-1:0]   statVec,
  output logic [3:0]         statLevel,
  output logic               stackErr,
  output logic [NUM_SRC-1:0] flags
);
  import irqarb_pkg::*;

  logic [NUM_SRC-1:0]        pend;
  logic [NUM_SRC*PRIO_W-1:0] prioFlat;
  logic                      winValid, stackEmpty, stackFull;
  logic [VEC_W-1:0]          winIdx;
  logic [PRIO_W-1:0]         winPrio;
  ctrl_strobe_t              strobe;

  irqarb_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) uPick (
    .pend(pend), .prioFlat(prioFlat),
    .winValid(winValid), .winIdx(winIdx), .winPrio(winPrio));

  irqarb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .winValid(winValid), .winPrio(winPrio),
    .cpuLevel(cpuLevel), .ack(ack), .ret(ret), .nestDis(nestDis),
    .iplWr(iplWr), .stackEmpty(stackEmpty), .stackFull(stackFull),
    .irqReq(irqReq), .strobe(strobe));

  irqarb_data #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .setPulse(setPulse), .clrMask(clrMask),
    .enWr(enWr), .enData(enData), .prioWr(prioWr), .prioIdx(prioIdx),
    .prioData(prioData), .iplData(iplData), .trapSet(trapSet),
    .trapClr(trapClr), .strobe(strobe), .winIdx(winIdx), .winPrio(winPrio),
    .pend(pend), .prioFlat(prioFlat), .flags(flags), .cpuLevel(cpuLevel),
    .statVec(statVec), .statLevel(statLevel), .stackErr(stackErr),
    .stackEmpty(stackEmpty), .stackFull(stackFull));

  assign irqVec   = winIdx;
  assign irqLevel = {1'b0, winPrio};

  // R4: status records the vector presented at the accepted edge
  assert_stat_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqReq && !ret && !stackFull) |=> statVec == $past(irqVec))
    else $error("status not captured");

  // R6: nesting disabled forces the field to 7 after an accept
  assert_nest_force_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqReq && !ret && !stackFull && nestDis) |=> cpuLevel[2:0] == 3'd7)
    else $error("nesting-disable not honoured");

  // R8: return on empty stack flags an error and keeps the level
  assert_empty_ret_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ret && stackEmpty && !trapSet && !trapClr) |=> (stackErr && $stable(cpuLevel)))
    else $error("empty return mishandled");

  // R11: an acknowledge on a full stack leaves the priority alone
  assert_full_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ack && stackFull && !ret && !iplWr && !trapSet && !trapClr) |=> $stable(cpuLevel))
    else $error("accept on full stack");
endmodule

// File: tb/irqarb_top_test.sv
`timescale 1ns/1ps
module irqarb_top_test;
  localparam int N = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] setPulse = '0, clrMask = '0, enData = '0;
  logic enWr = 0, prioWr = 0, iplWr = 0, trapSet = 0, trapClr = 0;
  logic nestDis = 0, ack = 0, ret = 0;
  logic [6:0] prioIdx = '0;
  logic [2:0] prioData = '0, iplData = '0;
  logic irqReq, stackErr;
  logic [6:0] irqVec, statVec;
  logic [3:0] irqLevel, cpuLevel, statLevel;
  logic [N-1:0] flags;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    string tag;
    int req, vec, lvl, cpu, stV, stL, err, flg;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  irqarb_top #(.NUM_SRC(N)) uut (
    .clk(clk), .rstN(rstN), .setPulse(setPulse), .clrMask(clrMask),
    .enWr(enWr), .enData(enData), .prioWr(prioWr), .prioIdx(prioIdx),
    .prioData(prioData), .iplWr(iplWr), .iplData(iplData),
    .trapSet(trapSet), .trapClr(trapClr), .nestDis(nestDis), .ack(ack),
    .ret(ret), .irqReq(irqReq), .irqVec(irqVec), .irqLevel(irqLevel),
    .cpuLevel(cpuLevel), .statVec(statVec), .statLevel(statLevel),
    .stackErr(stackErr), .flags(flags));

  function automatic bit chk(string tag, string f, int act, int ex);
    if (ex >= 0 && act != ex) begin
      $display("FAIL %s %s actual=%0d expected=%0d", tag, f, act, ex);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  // Monitor: outputs depend on registers only, so the falling edge is safe
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      checks++;
      bad = 0;
      bad |= chk(e.tag, "irqReq",    int'(irqReq),    e.req);
      bad |= chk(e.tag, "irqVec",    int'(irqVec),    e.vec);
      bad |= chk(e.tag, "irqLevel",  int'(irqLevel),  e.lvl);
      bad |= chk(e.tag, "cpuLevel",  int'(cpuLevel),  e.cpu);
      bad |= chk(e.tag, "statVec",   int'(statVec),   e.stV);
      bad |= chk(e.tag, "statLevel", int'(statLevel), e.stL);
      bad |= chk(e.tag, "stackErr",  int'(stackErr),  e.err);
      bad |= chk(e.tag, "flags",     int'(flags),     e.flg);
      if (bad) errors++;
    end
  end

  // Driver: inputs were set at a falling edge; one rising edge applies them
  task automatic cyc(string tag, int req, int vec, int lvl, int cpu,
                     int stV, int stL, int err, int flg);
    exp_t e;
    @(posedge clk);
    e.tag = tag; e.req = req; e.vec = vec; e.lvl = lvl; e.cpu = cpu;
    e.stV = stV; e.stL = stL; e.err = err; e.flg = flg;
    q.push_back(e);
    @(negedge clk);
    setPulse = '0; clrMask = '0; enWr = 0; prioWr = 0; iplWr = 0;
    trapSet = 0; trapClr = 0; ack = 0; ret = 0;
  endtask

  task automatic setPrio(int idx, int p);
    prioWr = 1; prioIdx = 7'(idx); prioData = 3'(p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    cyc("R9 reset state", 0, -1, -1, 0, 0, 0, 0, 0);

    setPulse = 16'h0020;
    cyc("R1 flag without enable", 0, -1, -1, 0, -1, -1, 0, 'h20);
    enWr = 1; enData = 16'h0020;
    cyc("R9 default level 4", 1, 5, 4, 0, -1, -1, 0, 'h20);
    setPrio(5, 0);
    cyc("R1 level 0 disabled", 0, -1, -1, 0, -1, -1, 0, -1);
    setPrio(5, 6);
    cyc("R3 single winner", 1, 5, 6, 0, -1, -1, 0, -1);
    setPulse = 16'h0008; enWr = 1; enData = 16'h0028;
    cyc("R3 higher level beats lower index", 1, 5, 6, 0, -1, -1, 0, 'h28);
    setPrio(3, 6);
    cyc("R3 tie goes to lowest index", 1, 3, 6, 0, -1, -1, 0, -1);
    iplWr = 1; iplData = 3'd6;
    cyc("R2 equal level masked", 0, -1, -1, 6, -1, -1, 0, -1);
    iplWr = 1; iplData = 3'd5;
    cyc("R2 greater level requests", 1, 3, 6, 5, -1, -1, 0, -1);
    ack = 1;
    cyc("R4 accept", 0, -1, -1, 6, 3, 6, 0, 'h28);
    setPulse = 16'h0002; enWr = 1; enData = 16'h002A;
    cyc("R2 lower source during service", 0, -1, -1, 6, 3, 6, 0, 'h2A);
    setPrio(1, 7);
    cyc("R3 nested higher source", 1, 1, 7, 6, -1, -1, 0, -1);
    ack = 1;
    cyc("R4 nested accept", 0, -1, -1, 7, 1, 7, 0, 'h2A);
    ret = 1;
    cyc("R8 pop restores", 1, 1, 7, 6, 1, 7, 0, -1);
    setPulse = 16'h0002; clrMask = 16'h0002;
    cyc("R10 set beats clear", 1, 1, 7, 6, -1, -1, 0, 'h2A);
    clrMask = 16'h0002;
    cyc("R5 same level stays pending", 0, 3, 6, 6, -1, -1, 0, 'h28);
    ret = 1;
    cyc("R5 released after return", 1, 3, 6, 5, -1, -1, 0, -1);
    ret = 1;
    cyc("R8 empty return", 1, -1, -1, 5, -1, -1, 1, -1);
    cyc("R8 error is one pulse", 1, -1, -1, 5, -1, -1, 0, -1);
    iplWr = 1; iplData = 3'd2; ack = 1;
    cyc("R7 accept overrides write", 0, -1, -1, 6, 3, 6, 0, -1);
    ret = 1; ack = 1;
    cyc("R13 return beats ack", 1, -1, -1, 5, -1, -1, 0, -1);
    iplWr = 1; iplData = 3'd6;
    cyc("R7 software write", 0, -1, -1, 6, -1, -1, 0, -1);
    iplWr = 1; iplData = 3'd5;
    cyc("R7 software write back", 1, -1, -1, 5, -1, -1, 0, -1);
    nestDis = 1; ack = 1;
    cyc("R6 accept forces 7", 0, -1, -1, 7, 3, 6, 0, -1);
    iplWr = 1; iplData = 3'd1;
    cyc("R6 write ignored", 0, -1, -1, 7, -1, -1, 0, -1);
    ret = 1;
    cyc("R6 return", 1, -1, -1, 5, -1, -1, 0, -1);
    nestDis = 0;
    trapSet = 1;
    cyc("R12 trap masks", 0, -1, -1, 13, -1, -1, 0, -1);
    trapSet = 1; trapClr = 1;
    cyc("R12 set beats clear", 0, -1, -1, 13, -1, -1, 0, -1);
    trapClr = 1;
    cyc("R12 trap cleared", 1, 3, 6, 5, -1, -1, 0, -1);
    for (int k = 0; k < 8; k++) begin
      iplWr = 1; iplData = 3'd0;
      cyc("R11 fill lower", 1, 3, 6, 0, -1, -1, 0, -1);
      ack = 1;
      cyc("R11 fill accept", 0, -1, -1, 6, 3, 6, 0, -1);
    end
    iplWr = 1; iplData = 3'd0;
    cyc("R11 lower before full ack", 1, 3, 6, 0, -1, -1, 0, -1);
    ack = 1;
    cyc("R11 ack on full ignored", 1, 3, 6, 0, 3, 6, 0, -1);
    ret = 1;
    cyc("R8 pop after full", 1, -1, -1, 0, -1, -1, 0, -1);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule